// File: doc/BRIEF.md
# Interrupt Factor Flag and Mask Controller

This block gathers one-cycle event pulses from the programmable timer, the serial port, the converter, the two stopwatch rates and the four clock-timer rates. Each pulse sets a factor flag, and the flags are held in four-bit groups that software reads over a nibble-wide register bus. Every flag has a mask bit next to it. The interrupt request to the CPU is high while any flag is set and its mask bit is 1. Reading a flag group returns its contents and clears that group in the same access, so software sees each event exactly once.

Two key sources are watched as well: a four-bit key group and one auxiliary key. Each key level passes through a synchronizer and is compared with a programmable comparison bit. Each key has a two-state machine. In `KS_MATCH` the synchronized level equals the comparison bit. In `KS_MISMATCH` it differs. The transition `KS_MATCH -> KS_MISMATCH` is the only one that raises a key event. The return transition `KS_MISMATCH -> KS_MATCH` is silent. For the key group, a per-bit selection register decides whether a bit's event reaches the shared group flag. The auxiliary key always reaches its own flag.

Reads are registered. Read data appears one cycle after the read strobe and holds until the next read.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, the following hold. All flags and all mask bits are 0. The key selection register (address 8) is 0. The group comparison register (address 9) reads 4'hF. The auxiliary comparison register (address 10) reads 4'h1. `irq` is 0.
- R2: An event pulse sets its flag on the next clock edge, whether or not the flag is masked. Flag positions are as follows. Address 0: bit0 programmable timer, bit1 serial, bit2 converter. Address 1: bit0 key group, bit1 auxiliary key. Address 2: bit0 stopwatch 10 Hz, bit1 stopwatch 1 Hz. Address 3: bit0 clock 32 Hz, bit1 8 Hz, bit2 2 Hz, bit3 1 Hz.
- R3: A read (`bus_rd` high for one cycle) updates `bus_rdata` at that clock edge. For a flag address (0 to 3), the value returned is the group before the edge, and the group is cleared at that same edge. `bus_rdata` holds between reads.
- R4: If an event pulse arrives in the same cycle as a read of its flag group, the read returns the earlier value and the flag is left set.
- R5: Mask registers sit at addresses 4 to 7, with the same bit positions as flag addresses 0 to 3. A mask bit of 1 enables its flag. `irq` is high exactly when some flag is set and its mask bit is 1.
- R6: A key-group bit whose selection bit (address 8, bit i for key i) is 1 sets the group flag when it enters `KS_MISMATCH`. `KS_MISMATCH` means the synchronized level differs from comparison bit i at address 9. The flag is set on the third rising edge after the input changes. The flag is also set when a write to the comparison register creates the mismatch.
- R7: The auxiliary key sets address 1 bit1 when it enters `KS_MISMATCH` against address 10 bit0. This key has no selection gate.
- R8: No event is raised in these cases: a key returning to `KS_MATCH`, a key that is not selected, or a key that is already in `KS_MISMATCH` when its selection bit is set.
- R9: Bits that are not used read as 0, and writes to them are ignored. Writes to the flag addresses 0 to 3 have no effect. Addresses above 10 read as 0.
- R10: The masks, the selection register and both comparison registers read back the value written to their used bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Register address |
| bus_wdata | input | 4 | Write data nibble |
| bus_rd | input | 1 | Read strobe; clears the addressed flag group |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 4 | Registered read data |
| ev_ptmr | input | 1 | Programmable timer event pulse |
| ev_sio | input | 1 | Serial interface event pulse |
| ev_adc | input | 1 | Converter event pulse |
| ev_sw10 | input | 1 | Stopwatch 10 Hz pulse |
| ev_sw1 | input | 1 | Stopwatch 1 Hz pulse |
| ev_ct32 | input | 1 | Clock timer 32 Hz pulse |
| ev_ct8 | input | 1 | Clock timer 8 Hz pulse |
| ev_ct2 | input | 1 | Clock timer 2 Hz pulse |
| ev_ct1 | input | 1 | Clock timer 1 Hz pulse |
| key_grp | input | KEY_W (4) | Key group levels, asynchronous |
| key_aux | input | 1 | Auxiliary key level, asynchronous |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench aims at several corner cases, and each one catches a specific design error:

- An event colliding with a read of its own group. A design where the clear wins would drop that event.
- A flag set while its mask is 0. A design that gated the flag by its mask would never record it.
- The exact three-edge latency from a key change to `irq`. A missing or extra synchronizer stage shifts the interrupt by a cycle.
- An unselected key, a key returning to its comparison level, and a key selected while already mismatched. Each of these must stay silent. An edge detector on raw levels, or one that ignores the per-key state, would raise false key interrupts.

A fixed-seed random phase mixes event pulses with clearing reads against a bench model of every flag group and `irq`.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NIB  = 4;
    localparam int NGRP = 4;

    localparam int A_FLAG_BASE = 0;
    localparam int A_MASK_BASE = 4;
    localparam int A_KEY_SEL   = 8;
    localparam int A_KEY_CMP   = 9;
    localparam int A_AUX_CMP   = 10;

    typedef enum logic {
        KS_MATCH    = 1'b0,
        KS_MISMATCH = 1'b1
    } key_state_e;

    function automatic logic [NIB-1:0] valid_of(input int g);
        case (g)
            0:       return 4'b0111;
            1:       return 4'b0011;
            2:       return 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/irq_key_detect.sv
module irq_key_detect
    import irq_pkg::*;
#(
    parameter int N           = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] keys,
    input  logic [N-1:0] cmp,
    input  logic [N-1:0] sel,
    output logic [N-1:0] ev
);

    for (genvar i = 0; i < N; i++) begin : g_key
        logic [SYNC_STAGES-1:0] sh;
        logic                   level;
        logic                   mis;
        key_state_e             st, st_nxt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '1;
            else        sh <= {sh[SYNC_STAGES-2:0], keys[i]};
        end

        assign level = sh[SYNC_STAGES-1];
        assign mis   = level ^ cmp[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st <= KS_MATCH;
            else        st <= st_nxt;
        end

        always_comb begin
            st_nxt = st;
            unique case (st)
                KS_MATCH:    if (mis)  st_nxt = KS_MISMATCH;
                KS_MISMATCH: if (!mis) st_nxt = KS_MATCH;
            endcase
        end

        always_comb begin
            ev[i] = 1'b0;
            unique case (st)
                KS_MATCH:    ev[i] = mis & sel[i];
                KS_MISMATCH: ev[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/irq_flag_nibble.sv
module irq_flag_nibble
    import irq_pkg::*;
#(
    parameter logic [NIB-1:0] VALID = 4'b1111
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NIB-1:0] set,
    input  logic           rd_clr,
    input  logic           mask_we,
    input  logic [NIB-1:0] wdata,
    output logic [NIB-1:0] flags,
    output logic [NIB-1:0] mask,
    output logic           req
);

    logic [NIB-1:0] kept;

    assign kept = rd_clr ? '0 : flags;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
            mask  <= '0;
        end else begin
            flags <= (kept | set) & VALID;
            if (mask_we) mask <= wdata & VALID;
        end
    end

    assign req = |(flags & mask);

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int KEY_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NIB-1:0]    bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [NIB-1:0]    bus_rdata,
    input  logic              ev_ptmr,
    input  logic              ev_sio,
    input  logic              ev_adc,
    input  logic              ev_sw10,
    input  logic              ev_sw1,
    input  logic              ev_ct32,
    input  logic              ev_ct8,
    input  logic              ev_ct2,
    input  logic              ev_ct1,
    input  logic [KEY_W-1:0]  key_grp,
    input  logic              key_aux,
    output logic              irq
);

    localparam int NKEY = KEY_W + 1;

    function automatic logic hit(input int a);
        return bus_addr == ADDR_W'(a);
    endfunction

    logic [KEY_W-1:0] sel_grp;
    logic [KEY_W-1:0] cmp_grp;
    logic             cmp_aux;
    logic [NKEY-1:0]  key_ev;
    logic             grp_ev;
    logic             aux_ev;
    logic [NIB-1:0]   set_v   [NGRP];
    logic [NIB-1:0]   flags_q [NGRP];
    logic [NIB-1:0]   mask_q  [NGRP];
    logic [NGRP-1:0]  req;
    logic [NGRP-1:0]  rd_clr;
    logic [NGRP-1:0]  mask_we;
    logic [NIB-1:0]   rd_nib;

    // Selection and comparison registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_grp <= '0;
            cmp_grp <= '1;
            cmp_aux <= 1'b1;
        end else if (bus_wr) begin
            if (hit(A_KEY_SEL)) sel_grp <= bus_wdata[KEY_W-1:0];
            if (hit(A_KEY_CMP)) cmp_grp <= bus_wdata[KEY_W-1:0];
            if (hit(A_AUX_CMP)) cmp_aux <= bus_wdata[0];
        end
    end

    irq_key_detect #(
        .N           (NKEY),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_keys (
        .clk   (clk),
        .rst_n (rst_n),
        .keys  ({key_aux, key_grp}),
        .cmp   ({cmp_aux, cmp_grp}),
        .sel   ({1'b1, sel_grp}),
        .ev    (key_ev)
    );

    assign grp_ev = |key_ev[KEY_W-1:0];
    assign aux_ev = key_ev[KEY_W];

    always_comb begin
        set_v[0] = {1'b0, ev_adc, ev_sio, ev_ptmr};
        set_v[1] = {2'b00, aux_ev, grp_ev};
        set_v[2] = {2'b00, ev_sw1, ev_sw10};
        set_v[3] = {ev_ct1, ev_ct2, ev_ct8, ev_ct32};
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign rd_clr[g]  = bus_rd && hit(A_FLAG_BASE + g);
        assign mask_we[g] = bus_wr && hit(A_MASK_BASE + g);

        irq_flag_nibble #(
            .VALID (valid_of(g))
        ) u_nib (
            .clk     (clk),
            .rst_n   (rst_n),
            .set     (set_v[g]),
            .rd_clr  (rd_clr[g]),
            .mask_we (mask_we[g]),
            .wdata   (bus_wdata),
            .flags   (flags_q[g]),
            .mask    (mask_q[g]),
            .req     (req[g])
        );
    end

    assign irq = |req;

    // Read mux
    always_comb begin
        rd_nib = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (hit(A_FLAG_BASE + g)) rd_nib = flags_q[g];
            if (hit(A_MASK_BASE + g)) rd_nib = mask_q[g];
        end
        if (hit(A_KEY_SEL)) rd_nib[KEY_W-1:0] = sel_grp;
        if (hit(A_KEY_CMP)) rd_nib[KEY_W-1:0] = cmp_grp;
        if (hit(A_AUX_CMP)) rd_nib[0]         = cmp_aux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_nib;
    end

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        rdata_hi,
    input logic              irq,
    input logic              ev_ptmr,
    input logic              ev_ct32,
    input logic              ev_ct8,
    input logic              ev_ct2,
    input logic              ev_ct1,
    input logic              grp_ev,
    input logic              flag_tmr0,
    input logic              flag_key0,
    input logic [3:0]        flag_ct,
    input logic [3:0]        mask_tmr,
    input logic [3:0]        mask_key,
    input logic [3:0]        mask_sw,
    input logic [3:0]        mask_ct
);

    a_r2_masked_set: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ct1 |=> flag_ct[3]);

    a_r3_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(3) && !(ev_ct32 || ev_ct8 || ev_ct2 || ev_ct1))
        |=> flag_ct == 4'b0000);

    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ptmr |=> flag_tmr0);

    a_r5_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_tmr | mask_key | mask_sw | mask_ct) == 4'b0000) |-> !irq);

    a_r6_group_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_key0) |-> $past(grp_ev));

    a_r9_unused_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(1)) |=> rdata_hi == 2'b00);

endmodule

bind irq_ctrl irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .rdata_hi  (bus_rdata[3:2]),
    .irq       (irq),
    .ev_ptmr   (ev_ptmr),
    .ev_ct32   (ev_ct32),
    .ev_ct8    (ev_ct8),
    .ev_ct2    (ev_ct2),
    .ev_ct1    (ev_ct1),
    .grp_ev    (grp_ev),
    .flag_tmr0 (flags_q[0][0]),
    .flag_key0 (flags_q[1][0]),
    .flag_ct   (flags_q[3]),
    .mask_tmr  (mask_q[0]),
    .mask_key  (mask_q[1]),
    .mask_sw   (mask_q[2]),
    .mask_ct   (mask_q[3])
);

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [3:0] bus_wdata = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_rdata;
    logic       ev_ptmr = 0, ev_sio = 0, ev_adc = 0, ev_sw10 = 0, ev_sw1 = 0;
    logic       ev_ct32 = 0, ev_ct8 = 0, ev_ct2 = 0, ev_ct1 = 0;
    logic [3:0] key_grp = 4'hF;
    logic       key_aux = 1'b1;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [3:0] mf [4];
    logic [3:0] mm [4];

    always #4 clk = ~clk;

    irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .ev_ptmr(ev_ptmr), .ev_sio(ev_sio), .ev_adc(ev_adc),
        .ev_sw10(ev_sw10), .ev_sw1(ev_sw1), .ev_ct32(ev_ct32), .ev_ct8(ev_ct8),
        .ev_ct2(ev_ct2), .ev_ct1(ev_ct1), .key_grp(key_grp), .key_aux(key_aux),
        .irq(irq)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [8:0] ev, input logic rd, input logic [3:0] a,
                       input logic wr, input logic [3:0] wd);
        @(negedge clk);
        {ev_ct1, ev_ct2, ev_ct8, ev_ct32, ev_sw1, ev_sw10, ev_adc, ev_sio, ev_ptmr} = ev;
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        @(posedge clk);
        #1;
        {ev_ct1, ev_ct2, ev_ct8, ev_ct32, ev_sw1, ev_sw10, ev_adc, ev_sio, ev_ptmr} = '0;
        bus_rd = 0; bus_wr = 0;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [3:0] d);
        cyc(9'd0, 1'b0, a, 1'b1, d);
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [3:0] v);
        cyc(9'd0, 1'b1, a, 1'b0, 4'h0);
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(9'd0, 1'b0, 4'h0, 1'b0, 4'h0);
    endtask

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int g = 0; g < 4; g++) r |= |(mf[g] & mm[g]);
        return r;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [3:0] v;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {3'b0, irq}, 4'h0);
        for (int a = 0; a < 9; a++) begin
            rd_reg(a[3:0], v);
            check("R1 reg zero", v, 4'h0);
        end
        rd_reg(4'd9, v);  check("R1 group cmp", v, 4'hF);
        rd_reg(4'd10, v); check("R1 aux cmp", v, 4'h1);

        // R2 masked set, R3 clear on read
        cyc(9'b000000100, 0, 0, 0, 0);
        check("R2 masked irq low", {3'b0, irq}, 4'h0);
        rd_reg(4'd0, v); check("R2 adc flag", v, 4'b0100);
        rd_reg(4'd0, v); check("R3 cleared", v, 4'h0);
        cyc(9'b101000000, 0, 0, 0, 0);
        rd_reg(4'd3, v); check("R2 ct bits", v, 4'b1010);
        cyc(9'b000010000, 0, 0, 0, 0);
        rd_reg(4'd2, v); check("R2 sw1 bit", v, 4'b0010);
        idle(2);
        check("R3 rdata holds", bus_rdata, 4'b0010);

        // R4 event colliding with read
        cyc(9'b000000001, 1, 0, 0, 0);
        check("R4 read returns prior", bus_rdata, 4'h0);
        rd_reg(4'd0, v); check("R4 flag kept", v, 4'b0001);

        // R5 mask gating
        wr_reg(4'd4, 4'b0001);
        cyc(9'b000000010, 0, 0, 0, 0);
        check("R5 masked sio no irq", {3'b0, irq}, 4'h0);
        cyc(9'b000000001, 0, 0, 0, 0);
        check("R5 irq on enabled flag", {3'b0, irq}, 4'h1);
        rd_reg(4'd0, v); check("R5 flags", v, 4'b0011);
        check("R5 irq after clear", {3'b0, irq}, 4'h0);
        wr_reg(4'd4, 4'b0000);

        // R9 / R10
        wr_reg(4'd0, 4'hF);
        rd_reg(4'd0, v); check("R9 flag write ignored", v, 4'h0);
        wr_reg(4'd4, 4'hF);
        rd_reg(4'd4, v); check("R9 unused mask bits", v, 4'b0111);
        wr_reg(4'd4, 4'h0);
        wr_reg(4'd7, 4'hA);
        rd_reg(4'd7, v); check("R10 mask readback", v, 4'hA);
        wr_reg(4'd7, 4'h0);
        rd_reg(4'd12, v); check("R9 unmapped zero", v, 4'h0);

        // R6 / R8 key group
        wr_reg(4'd8, 4'b0010);
        wr_reg(4'd5, 4'b0011);
        rd_reg(4'd8, v); check("R10 sel readback", v, 4'b0010);
        @(negedge clk) key_grp[0] = 1'b0;
        idle(5);
        rd_reg(4'd1, v); check("R8 unselected key", v, 4'h0);
        @(negedge clk) key_grp[1] = 1'b0;
        @(posedge clk); #1 check("R6 latency edge1", {3'b0, irq}, 4'h0);
        @(posedge clk); #1 check("R6 latency edge2", {3'b0, irq}, 4'h0);
        @(posedge clk); #1 check("R6 latency edge3", {3'b0, irq}, 4'h1);
        rd_reg(4'd1, v); check("R6 group flag", v, 4'b0001);
        check("R6 irq cleared", {3'b0, irq}, 4'h0);
        @(negedge clk) key_grp[1] = 1'b1;
        idle(5);
        rd_reg(4'd1, v); check("R8 return to match", v, 4'h0);
        wr_reg(4'd8, 4'b0011);
        idle(3);
        rd_reg(4'd1, v); check("R8 select while mismatched", v, 4'h0);
        wr_reg(4'd9, 4'b1110);
        idle(2);
        rd_reg(4'd1, v); check("R8 cmp makes match", v, 4'h0);
        @(negedge clk) key_grp[0] = 1'b1;
        idle(5);
        rd_reg(4'd1, v); check("R6 mismatch vs new cmp", v, 4'b0001);
        rd_reg(4'd9, v); check("R10 cmp readback", v, 4'hE);

        // R7 auxiliary key
        @(negedge clk) key_aux = 1'b0;
        idle(5);
        rd_reg(4'd1, v); check("R7 aux flag", v, 4'b0010);
        wr_reg(4'd10, 4'h0);
        rd_reg(4'd10, v); check("R10 aux cmp readback", v, 4'h0);
        @(negedge clk) key_aux = 1'b1;
        idle(5);
        rd_reg(4'd1, v); check("R7 aux vs new cmp", v, 4'b0010);
        rd_reg(4'd1, v); check("R7 cleared", v, 4'h0);

        // Random phase (R2 R3 R4 R5)
        for (int g = 0; g < 4; g++) begin
            mf[g] = 4'h0;
            mm[g] = 4'($urandom) & ((g == 0) ? 4'b0111 : (g == 3) ? 4'b1111 : 4'b0011);
            if (g == 1) mm[g] = 4'h0;
            wr_reg(4'(4 + g), mm[g]);
        end
        for (int i = 0; i < 400; i++) begin
            logic [8:0] ev;
            logic       rd;
            logic [3:0] a;
            logic [3:0] exp;
            ev  = 9'($urandom) & 9'($urandom);
            rd  = ($urandom % 3) == 0;
            a   = 4'($urandom % 4);
            exp = mf[a];
            cyc(ev, rd, a, 1'b0, 4'h0);
            if (rd) begin
                check("R3 random read", bus_rdata, exp);
                mf[a] = 4'h0;
            end
            mf[0] |= {1'b0, ev[2:0]};
            mf[2] |= {2'b00, ev[4:3]};
            mf[3] |= ev[8:5];
            check("R5 random irq", {3'b0, irq}, {3'b0, exp_irq()});
        end
        for (int g = 0; g < 4; g++) begin
            rd_reg(4'(g), v);
            check("R4 final flags", v, mf[g]);
        end

        finish_run();
    end

endmodule